// File: doc/BRIEF.md
# Per-Block Lock Register Bank

This block keeps one small lock register for every 64 KB block of a flash array. Each register holds three bits: a read lock, a write lock and a lock-down bit. Software reaches the registers through a register port that carries a block index, write data and a write strobe. The same port returns the indexed register on a combinational read path. The write lock is set in every register when the block leaves reset. Once the lock-down bit of a block is set, that register is frozen until the next reset.

A query port takes a byte address into the array and returns two qualifiers for the array access path: read-allowed and write-allowed. Read-allowed follows the read lock of the addressed block. Write-allowed is the combination of three things: the write lock of the addressed block, an active-low pin that guards the top-most block, and an active-low general pin that guards every other block. The pins act on the qualifiers only and never change the stored register contents.

Top module: `blk_lock_bank`

## Requirements
- R1: Reset is synchronous and active high. During reset and after it, every block register reads 3'b001, which means write-locked, read-unlocked and not locked down.
- R2: A write strobe to a block that is not locked down stores reg_wdata[2:0] in the indexed register only. The bit meanings are: bit 0 write lock, bit 1 lock-down, bit 2 read lock. The new value is readable one cycle after the strobe edge.
- R3: Once bit 1 (lock-down) of a register is set, later writes to that register leave all three bits unchanged, whatever the data.
- R4: Reset returns a locked-down register to 3'b001.
- R5: q_rd_ok is low exactly when the read lock of the addressed block is set.
- R6: q_wr_ok is low whenever the write lock of the addressed block is set.
- R7: While top_lock_n is low, q_wr_ok is low for the top block (index NUM_BLOCKS-1), whatever its register holds. Other blocks are not affected by this pin.
- R8: While wp_n is low, q_wr_ok is low for every block except the top block. The top block is not affected by this pin.
- R9: The block is selected by q_addr bits above the 16-bit in-block offset. The offset bits have no effect on the qualifiers.
- R10: reg_rdata carries the three lock bits in bits 2:0, and all bits above them read zero. Write data above bit 2 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | IDX_W (4) | Block index for register access |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W (8) | Register write data |
| reg_rdata | output | DATA_W (8) | Indexed register contents, zero-extended |
| top_lock_n | input | 1 | Active-low write guard for the top block |
| wp_n | input | 1 | Active-low write guard for all other blocks |
| q_addr | input | ADDR_W (20) | Byte address into the array |
| q_rd_ok | output | 1 | Array read permitted at q_addr |
| q_wr_ok | output | 1 | Program or erase permitted at q_addr |

## Verification
The bench builds the block with its default parameters: 16 blocks of 64 KB and a 20-bit address. This puts index 15 at the top of the map, so the two protect pins can be checked against the top block and against ordinary blocks in the same run. Queries use both the lowest and the highest offset inside a block, which shows that the offset bits are ignored. A second reset at the end checks that it clears a locked-down register.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
    // Packed order gives the register bit positions:
    // rd_lock is bit 2, lock_down is bit 1, wr_lock is bit 0.
    typedef struct packed {
        logic rd_lock;
        logic lock_down;
        logic wr_lock;
    } lock_bits_t;

    localparam int LOCK_W = 3;
    localparam lock_bits_t LOCK_RESET = '{rd_lock: 1'b0, lock_down: 1'b0, wr_lock: 1'b1};

    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
    } perm_t;

    // Combine the stored lock bits with the two active-low protect pins.
    function automatic perm_t eval_perm(lock_bits_t lb, logic is_top,
                                        logic top_lock_n, logic wp_n);
        perm_t p;
        p.rd_ok = ~lb.rd_lock;
        p.wr_ok = ~lb.wr_lock & (is_top ? top_lock_n : wp_n);
        return p;
    endfunction
endpackage

// File: rtl/lock_cell.sv
module lock_cell
    import blk_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_sel,
    input  lock_bits_t wr_val,
    output lock_bits_t state
);
    always_ff @(posedge clk) begin
        if (rst)
            state <= LOCK_RESET;
        else if (wr_sel && !state.lock_down)
            state <= wr_val;
    end

    p_reset_val_r1: assert property (@(posedge clk) rst |=> state == LOCK_RESET)
        else $error("lock cell not at reset value");
    p_down_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        state.lock_down |=> $stable(state))
        else $error("locked-down cell changed");
endmodule

// File: rtl/perm_eval.sv
module perm_eval
    import blk_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  lock_bits_t       cells [NUM_BLOCKS],
    input  logic [IDX_W-1:0] idx,
    input  logic             top_lock_n,
    input  logic             wp_n,
    output perm_t            perm
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NUM_BLOCKS - 1);

    lock_bits_t sel;
    logic       is_top;

    assign sel    = cells[idx];
    assign is_top = (idx == TOP_IDX);
    assign perm   = eval_perm(sel, is_top, top_lock_n, wp_n);

    p_top_pin_r7: assert property (@(posedge clk) disable iff (rst)
        (is_top && !top_lock_n) |-> !perm.wr_ok)
        else $error("top block writable with guard low");
    p_wp_pin_r8: assert property (@(posedge clk) disable iff (rst)
        (!is_top && !wp_n) |-> !perm.wr_ok)
        else $error("block writable with wp low");
endmodule

// File: rtl/blk_lock_bank.sv
module blk_lock_bank
    import blk_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 16,
    parameter int OFS_W      = 16,
    parameter int DATA_W     = 8,
    localparam int IDX_W  = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
    localparam int ADDR_W = IDX_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              top_lock_n,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] q_addr,
    output logic              q_rd_ok,
    output logic              q_wr_ok
);
    lock_bits_t cells [NUM_BLOCKS];
    lock_bits_t wr_val;
    perm_t      perm;

    assign wr_val = lock_bits_t'(reg_wdata[LOCK_W-1:0]);

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_cell
        lock_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .wr_sel (reg_wr && (reg_idx == IDX_W'(b))),
            .wr_val (wr_val),
            .state  (cells[b])
        );
    end

    assign reg_rdata = {{(DATA_W-LOCK_W){1'b0}}, cells[reg_idx]};

    perm_eval #(.NUM_BLOCKS(NUM_BLOCKS)) u_perm (
        .clk        (clk),
        .rst        (rst),
        .cells      (cells),
        .idx        (q_addr[ADDR_W-1:OFS_W]),
        .top_lock_n (top_lock_n),
        .wp_n       (wp_n),
        .perm       (perm)
    );

    assign q_rd_ok = perm.rd_ok;
    assign q_wr_ok = perm.wr_ok;

    p_rdata_upper_r10: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[DATA_W-1:LOCK_W] == '0)
        else $error("upper read bits not zero");
endmodule

// File: tb/blk_lock_bank_tb.sv
module blk_lock_bank_tb;
    localparam int NB = 16;
    logic        clk = 0;
    logic        rst = 1;
    logic [3:0]  reg_idx = '0;
    logic        reg_wr = 0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        top_lock_n = 1;
    logic        wp_n = 1;
    logic [19:0] q_addr = '0;
    logic        q_rd_ok, q_wr_ok;
    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    blk_lock_bank u_dut (.*);

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(int idx, logic [7:0] d);
        @(negedge clk);
        reg_idx = 4'(idx); reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd_reg(string req, int idx, logic [7:0] exp);
        reg_idx = 4'(idx);
        #0.5;
        chk(req, reg_rdata, exp);
    endtask

    task automatic query(string req, int blk, logic [15:0] ofs, logic rd, logic wr);
        q_addr = {4'(blk), ofs};
        #0.5;
        chk({req, " rd"}, {7'd0, q_rd_ok}, {7'd0, rd});
        chk({req, " wr"}, {7'd0, q_wr_ok}, {7'd0, wr});
    endtask

    task automatic t_reset();
        for (int b = 0; b < NB; b++) rd_reg("R1 reset value", b, 8'h01);
        query("R1 R6 reset perms", 0, 16'h0000, 1, 0);
        query("R1 R6 reset perms top", 15, 16'hFFFF, 1, 0);
    endtask

    task automatic t_write();
        wr_reg(3, 8'h00);
        rd_reg("R2 write blk3", 3, 8'h00);
        rd_reg("R2 neighbour untouched", 4, 8'h01);
        query("R6 R9 blk3 lo", 3, 16'h0000, 1, 1);
        query("R9 blk3 hi", 3, 16'hFFFF, 1, 1);
        query("R6 blk4 still locked", 4, 16'h0000, 1, 0);
        wr_reg(5, 8'hFC);
        rd_reg("R10 upper ignored", 5, 8'h04);
        query("R5 read lock", 5, 16'h8000, 0, 1);
    endtask

    task automatic t_lockdown();
        wr_reg(6, 8'h02);
        rd_reg("R2 lock-down set", 6, 8'h02);
        wr_reg(6, 8'h07);
        rd_reg("R3 sticky after write", 6, 8'h02);
        wr_reg(6, 8'h00);
        rd_reg("R3 clear ignored", 6, 8'h02);
        query("R3 perms frozen", 6, 16'h1234, 1, 1);
    endtask

    task automatic t_pins();
        wr_reg(15, 8'h00);
        wr_reg(2, 8'h00);
        query("R7 baseline top", 15, 16'h0000, 1, 1);
        @(negedge clk); top_lock_n = 0;
        query("R7 top blocked", 15, 16'h0000, 1, 0);
        query("R7 other free", 2, 16'h0000, 1, 1);
        rd_reg("R7 reg unchanged", 15, 8'h00);
        @(negedge clk); top_lock_n = 1; wp_n = 0;
        query("R8 other blocked", 2, 16'hFFFF, 1, 0);
        query("R8 top free", 15, 16'hFFFF, 1, 1);
        @(negedge clk); wp_n = 1;
        query("R8 released", 2, 16'h0000, 1, 1);
    endtask

    task automatic t_reset2();
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        rd_reg("R4 lockdown cleared", 6, 8'h01);
        rd_reg("R4 blk3 restored", 3, 8'h01);
        wr_reg(6, 8'h00);
        rd_reg("R4 writable again", 6, 8'h00);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rd_reg("R1 during reset", 7, 8'h01);
                rst = 0;
                t_reset();
                t_write();
                t_lockdown();
                t_pins();
                t_reset2();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++;
                $display("FAIL watchdog act=hung exp=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule